// File: doc/BRIEF.md
# Transmit/Receive Word Queue Pair with Level Flags

This block holds the data words of a serial peripheral in two first-in first-out queues of 32-bit words. The transmit queue is filled from the register bus and drained by the shift engine. The receive queue is filled by the shift engine and drained by the register bus. Each queue reports its fill level, and both levels are packed into a single status word.

A latched flag register records six conditions:
- the transmit level at or below a programmable low mark;
- the receive level at or above the same mark;
- receive queue full;
- transmit queue empty;
- a read from an empty receive queue;
- a write to a full transmit queue.

Software clears flags by writing ones to them. An enable register selects which flags drive the single interrupt output.

Each queue can be emptied in one cycle by its own clear input. A clear leaves the latched flags alone, so an error from before the clear is still visible to software afterwards.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both queues are empty and the flag and enable registers are zero. The status word reads 0x0010_0000 (receive-empty bit set). One cycle later the flag register reads 0x0000_0220 (transmit-empty and transmit-mark flags) with the default mark code 0.
- R2: Each queue holds 16 words and returns them in write order. The read side shows the head word combinationally. The status word carries the transmit level in bits 15:8 and the receive level in bits 31:24, each zero-extended.
- R3: A transmit push while the queue holds 16 words is discarded, the level stays 16, and flag bit 17 is set. That bit stays set until software clears it.
- R4: A receive pop while the queue is empty returns zero, leaves the queue pointers and level unchanged, and sets flag bit 16.
- R5: The 2-bit mark code selects 8 entries (code 0), 4 entries (code 1) or 1 entry (code 2).
- R6: Flag bit 5 is set when the transmit level is less than or equal to the mark. Flag bit 4 is set when the receive level is greater than or equal to the mark. Both are set one cycle after the level is registered.
- R7: Status bit 4 shows transmit full and status bit 20 shows receive empty. Flag bit 8 records receive full and flag bit 9 records transmit empty.
- R8: A write to the flag register clears exactly the bits written as one, taking priority over any set in that cycle. Writing all ones leaves every flag zero in the following cycle.
- R9: The interrupt output is high exactly when some flag bit and its enable bit are both one.
- R10: A queue clear drops the level to zero at the next edge and leaves every latched flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mark_code | input | 2 | Mark select: 0 = 8, 1 = 4, 2 = 1 entries |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_clr | input | 1 | Empty the receive queue |
| tx_push | input | 1 | Bus write into transmit queue |
| tx_push_data | input | 32 | Word written into transmit queue |
| tx_pop | input | 1 | Shift engine takes the transmit head |
| tx_pop_data | output | 32 | Transmit head word (zero when empty) |
| rx_push | input | 1 | Shift engine writes into receive queue |
| rx_push_data | input | 32 | Word written into receive queue |
| rx_pop | input | 1 | Bus read from receive queue |
| rx_pop_data | output | 32 | Receive head word (zero when empty) |
| status | output | 32 | Packed levels, transmit full, receive empty |
| flag_wr | input | 1 | Write-one-to-clear strobe for flags |
| flag_wr_data | input | 32 | Bits of flags to clear |
| en_wr | input | 1 | Enable register write strobe |
| en_wr_data | input | 32 | New enable register value |
| flags | output | 32 | Latched flag register |
| irq | output | 1 | Interrupt request |

## Verification
Each queue is filled to every level from 0 to 16 under each of the three mark codes. At each level the packed level fields, the full and empty bits and the mark flags are compared with arithmetic expectations. This separates a less-than from a less-or-equal compare, a swapped code decode and a misplaced field. Full queues are drained word by word, which exposes pointer wrap and ordering faults. Directed sequences push into a full queue, pop from an empty one and clear a queue with flags pending. These show whether bad accesses are dropped and whether latched flags survive a clear. Selective and all-ones clears combined with different enable masks check flag clearing and interrupt gating separately.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    // flag register bit positions
    localparam int FLG_RX_MARK  = 4;
    localparam int FLG_TX_MARK  = 5;
    localparam int FLG_RX_FULL  = 8;
    localparam int FLG_TX_EMPTY = 9;
    localparam int FLG_RX_UNDER = 16;
    localparam int FLG_TX_OVER  = 17;

    // status word field positions
    localparam int ST_TX_FULL  = 4;
    localparam int ST_TX_LVL   = 8;
    localparam int ST_RX_EMPTY = 20;
    localparam int ST_RX_LVL   = 24;
    localparam int ST_LVL_W    = 8;

    localparam logic [31:0] FLAG_MASK =
        (32'd1 << FLG_RX_MARK)  | (32'd1 << FLG_TX_MARK)  |
        (32'd1 << FLG_RX_FULL)  | (32'd1 << FLG_TX_EMPTY) |
        (32'd1 << FLG_RX_UNDER) | (32'd1 << FLG_TX_OVER);

    typedef enum logic [1:0] {
        MARK_8   = 2'd0,
        MARK_4   = 2'd1,
        MARK_1   = 2'd2,
        MARK_RSV = 2'd3
    } mark_code_e;

    // entries selected by a mark code; the unused code behaves as a mark of 1
    function automatic int unsigned mark_entries(logic [1:0] code);
        case (mark_code_e'(code))
            MARK_8:  return 8;
            MARK_4:  return 4;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/spi_fifo_core.sv
module spi_fifo_core #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             over_evt,
    output logic             under_evt
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [LW-1:0] cnt;
    } core_st_t;

    core_st_t          st_d, st_q;
    logic [WIDTH-1:0]  mem_q [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (st_q.cnt == LW'(DEPTH));
        empty     = (st_q.cnt == '0);
        do_push   = push && !full  && !clr;
        do_pop    = pop  && !empty && !clr;
        over_evt  = push && full  && !clr;
        under_evt = pop  && empty && !clr;

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = ptr_next(st_q.wr);
            if (do_pop)  st_d.rd = ptr_next(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
        level     = st_q.cnt;
        head_data = empty ? '0 : mem_q[st_q.rd];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= push_data;
    end

    // R2: level never exceeds the depth
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R3: a push into a full queue without a pop leaves the level at depth
    assert_drop_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (level == LW'(DEPTH)));

    // R4: a pop from an empty queue without a push leaves it empty
    assert_underrun_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> empty);

    // R10: a clear empties the queue at the next edge
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0));

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags #(
    parameter int          FW   = 32,
    parameter logic [FW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] set_vec,
    input  logic          clr_wr,
    input  logic [FW-1:0] clr_data,
    input  logic          en_wr,
    input  logic [FW-1:0] en_data,
    output logic [FW-1:0] flags,
    output logic          irq
);

    typedef struct packed {
        logic [FW-1:0] flg;
        logic [FW-1:0] en;
    } flag_st_t;

    flag_st_t      st_d, st_q;
    logic [FW-1:0] clr_bits;

    always_comb begin
        clr_bits   = clr_wr ? clr_data : '0;
        st_d       = st_q;
        st_d.flg   = (st_q.flg | set_vec) & ~clr_bits & MASK;
        if (en_wr) st_d.en = en_data & MASK;
        flags      = st_q.flg;
        irq        = |(st_q.flg & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: an all-ones write leaves nothing set
    assert_w1c_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (clr_data == '1)) |=> (flags == '0));

    // R3: latched bits persist while no clear is written
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flags & $past(flags)) == $past(flags)));

    // R9: interrupt low whenever the enable register is zero
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && (en_data == '0)) |=> !irq);

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mark_code,
    input  logic             tx_clr,
    input  logic             rx_clr,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_push_data,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_pop_data,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_push_data,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_pop_data,
    output logic [31:0]      status,
    input  logic             flag_wr,
    input  logic [31:0]      flag_wr_data,
    input  logic             en_wr,
    input  logic [31:0]      en_wr_data,
    output logic [31:0]      flags,
    output logic             irq
);

    logic [LW-1:0] tx_lvl, rx_lvl, mark_lvl;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_over, tx_under_unused, rx_over_unused, rx_under;
    logic [31:0]   set_vec;

    spi_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tx_clr),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .head_data (tx_pop_data),
        .level     (tx_lvl),
        .full      (tx_full),
        .empty     (tx_empty),
        .over_evt  (tx_over),
        .under_evt (tx_under_unused)
    );

    spi_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .head_data (rx_pop_data),
        .level     (rx_lvl),
        .full      (rx_full),
        .empty     (rx_empty),
        .over_evt  (rx_over_unused),
        .under_evt (rx_under)
    );

    always_comb begin
        mark_lvl = LW'(mark_entries(mark_code));

        set_vec               = '0;
        set_vec[FLG_TX_MARK]  = (tx_lvl <= mark_lvl);
        set_vec[FLG_RX_MARK]  = (rx_lvl >= mark_lvl);
        set_vec[FLG_RX_FULL]  = rx_full;
        set_vec[FLG_TX_EMPTY] = tx_empty;
        set_vec[FLG_RX_UNDER] = rx_under;
        set_vec[FLG_TX_OVER]  = tx_over;

        status                                 = '0;
        status[ST_TX_FULL]                     = tx_full;
        status[ST_RX_EMPTY]                    = rx_empty;
        status[ST_TX_LVL +: ST_LVL_W]          = ST_LVL_W'(tx_lvl);
        status[ST_RX_LVL +: ST_LVL_W]          = ST_LVL_W'(rx_lvl);
    end

    spi_fifo_flags #(.FW(32), .MASK(FLAG_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (flag_wr),
        .clr_data (flag_wr_data),
        .en_wr    (en_wr),
        .en_data  (en_wr_data),
        .flags    (flags),
        .irq      (irq)
    );

    // R6: a transmit level at or under the mark is latched one cycle later
    assert_tx_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_lvl <= mark_lvl) && !flag_wr) |=> flags[FLG_TX_MARK]);

    // R4: an empty receive read returns zero
    assert_under_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |-> (rx_pop_data == '0));

    // R3: an overflowing push is recorded
    assert_over_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !tx_clr && !flag_wr) |=> flags[FLG_TX_OVER]);

    // R10: a clear alone does not drop latched flags
    assert_clear_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_clr || rx_clr) && !flag_wr) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: tb/spi_fifo_pair_bench.sv
module spi_fifo_pair_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mark_code = 2'd0;
    logic        tx_clr = 0, rx_clr = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic [31:0] tx_push_data = 0, rx_push_data = 0;
    logic [31:0] tx_pop_data, rx_pop_data, status, flags;
    logic        flag_wr = 0, en_wr = 0, irq;
    logic [31:0] flag_wr_data = 0, en_wr_data = 0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    spi_fifo_pair u_spi_fifo_pair (
        .clk(clk), .rst_n(rst_n), .mark_code(mark_code),
        .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .status(status), .flag_wr(flag_wr), .flag_wr_data(flag_wr_data),
        .en_wr(en_wr), .en_wr_data(en_wr_data), .flags(flags), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic w1c(logic [31:0] bits);
        flag_wr = 1; flag_wr_data = bits; tick(); flag_wr = 0; flag_wr_data = 0;
    endtask

    task automatic clear_all();
        tx_clr = 1; rx_clr = 1; tick(); tx_clr = 0; rx_clr = 0;
        w1c('1);
    endtask

    task automatic push_tx(logic [31:0] d);
        tx_push = 1; tx_push_data = d; tick(); tx_push = 0;
    endtask

    task automatic push_rx(logic [31:0] d);
        rx_push = 1; rx_push_data = d; tick(); rx_push = 0;
    endtask

    function automatic int mark_of(int c);
        return (c == 0) ? 8 : (c == 1) ? 4 : 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", status, 32'h0010_0000);
        chk("R1 flags", flags, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        tick();
        chk("R1 flags after one cycle", flags, 32'h0000_0220);

        // R2 R5 R6 R7 transmit sweep over all levels and codes
        for (int c = 0; c < 3; c++) begin
            mark_code = 2'(c);
            for (int k = 0; k <= 16; k++) begin
                clear_all();
                for (int i = 0; i < k; i++) push_tx(32'hA000_0000 + 32'(i * 3 + c));
                w1c('1);
                tick();
                chk("R2 tx level field", {24'b0, status[15:8]}, 32'(k));
                chk("R7 tx full bit", {31'b0, status[4]}, {31'b0, k == 16});
                chk("R6 R5 tx mark flag", {31'b0, flags[5]}, {31'b0, k <= mark_of(c)});
                chk("R7 tx empty flag", {31'b0, flags[9]}, {31'b0, k == 0});
                if (k == 16) begin
                    for (int i = 0; i < 16; i++) begin
                        chk("R2 tx order", tx_pop_data, 32'hA000_0000 + 32'(i * 3 + c));
                        tx_pop = 1; tick(); tx_pop = 0;
                    end
                    chk("R2 tx drained", {24'b0, status[15:8]}, 32'h0);
                end
            end
        end

        // R2 R5 R6 R7 receive sweep
        for (int c = 0; c < 3; c++) begin
            mark_code = 2'(c);
            for (int k = 0; k <= 16; k++) begin
                clear_all();
                for (int i = 0; i < k; i++) push_rx(32'h5000_0000 + 32'(i * 7 + c));
                w1c('1);
                tick();
                chk("R2 rx level field", {24'b0, status[31:24]}, 32'(k));
                chk("R7 rx empty bit", {31'b0, status[20]}, {31'b0, k == 0});
                chk("R6 R5 rx mark flag", {31'b0, flags[4]}, {31'b0, k >= mark_of(c)});
                chk("R7 rx full flag", {31'b0, flags[8]}, {31'b0, k == 16});
                if (k == 16) begin
                    for (int i = 0; i < 16; i++) begin
                        chk("R2 rx order", rx_pop_data, 32'h5000_0000 + 32'(i * 7 + c));
                        rx_pop = 1; tick(); rx_pop = 0;
                    end
                end
            end
        end

        // R3 overflow
        mark_code = 2'd0;
        clear_all();
        for (int i = 0; i < 16; i++) push_tx(32'h100 + 32'(i));
        push_tx(32'hDEAD_BEEF);
        chk("R3 overflow flag", {31'b0, flags[17]}, 32'h1);
        chk("R3 level stays 16", {24'b0, status[15:8]}, 32'd16);
        for (int i = 0; i < 16; i++) begin
            chk("R3 data kept", tx_pop_data, 32'h100 + 32'(i));
            tx_pop = 1; tick(); tx_pop = 0;
        end
        chk("R3 dropped word absent", tx_pop_data, 32'h0);
        chk("R3 flag sticky", {31'b0, flags[17]}, 32'h1);

        // R4 underrun
        clear_all();
        rx_pop = 1; #0;
        chk("R4 underrun data zero", rx_pop_data, 32'h0);
        tick(); rx_pop = 0;
        chk("R4 underrun flag", {31'b0, flags[16]}, 32'h1);
        chk("R4 level unchanged", {24'b0, status[31:24]}, 32'h0);
        push_rx(32'h0000_0055);
        chk("R4 pointers intact", rx_pop_data, 32'h0000_0055);
        chk("R4 level one", {24'b0, status[31:24]}, 32'h1);

        // R10 clear keeps flags
        push_rx(32'h66);
        rx_clr = 1; tick(); rx_clr = 0;
        chk("R10 rx level zero", {24'b0, status[31:24]}, 32'h0);
        chk("R10 underrun flag kept", {31'b0, flags[16]}, 32'h1);
        chk("R10 rx empty bit", {31'b0, status[20]}, 32'h1);

        // R9 interrupt gating and R8 selective clear
        chk("R9 irq off with zero enable", {31'b0, irq}, 32'h0);
        en_wr = 1; en_wr_data = 32'h0001_0000; tick(); en_wr = 0;
        chk("R9 irq on with enabled flag", {31'b0, irq}, 32'h1);
        en_wr = 1; en_wr_data = 32'h0002_0000; tick(); en_wr = 0;
        chk("R9 irq off with other enable", {31'b0, irq}, 32'h0);
        en_wr = 1; en_wr_data = 32'h0001_0000; tick(); en_wr = 0;
        w1c(32'h0001_0000);
        chk("R8 selected bit cleared", {31'b0, flags[16]}, 32'h0);
        chk("R8 other bits kept", {31'b0, flags[9]}, 32'h1);
        chk("R9 irq off after clear", {31'b0, irq}, 32'h0);
        w1c('1);
        chk("R8 all ones clears", flags, 32'h0);

        finish_run();
    end

endmodule